// File: doc/BRIEF.md
# Sequential Overlap-Add Symbol Buffer

This block builds the overlapping transmit stream of a filter-bank modulator. Each new block of K*N complex samples arrives, where N is the transform size and K is the overlap factor. The block slides its 2*K*N-entry accumulation buffer down by N/2 entries and clears the vacated top. It then sums the new samples into the upper half of the buffer and streams the lower K*N entries of the updated buffer out.

The buffer lives in an ordinary two-port RAM with one read and one write per cycle. The slide-and-add therefore walks the array one word per clock under a small state machine, and no register array is updated all at once. Input samples are first gathered into a K*N-deep staging RAM. The buffer pass follows, and then the output drain. Each phase waits for the one before it to finish.

After reset, a clearing pass writes zero to every buffer word. Only after that pass does the block accept its first sample.

Top module: `ola_seq_buffer`

## Requirements
- R1: After reset, `in_ready` and `out_valid` are low while a clearing pass runs. The buffer then holds all zeros, so the first output block is K*N zero samples.
- R2: `in_ready` is high only in the input phase. It drops after exactly K*N accepted samples and stays low through the update pass and until the last sample of the matching output block has been taken.
- R3: For each block, updated entry i equals the previous entry i+N/2, for i below 2*K*N-N/2.
- R4: The top N/2 entries are zero before the new samples are summed in.
- R5: Input sample j (index 0 to K*N-1 within the block) is added to updated entry K*N+j. The real and imaginary parts are added separately as 16-bit two's-complement values that wrap on overflow.
- R6: Each input block produces exactly K*N output samples. These are updated entries 0 to K*N-1, in increasing index order. The real part is on `out_re` and the imaginary part on `out_im`.
- R7: `out_last` is high only on output sample K*N-1, and only when `in_last` was high on at least one accepted sample of the matching input block.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_re`, `out_im` and `out_last` hold their values into the next cycle.
- R9: `in_valid`, `in_last` and input data are ignored while `in_ready` is low, and they leave later outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_re | input | 16 | Input sample, real part, signed |
| in_im | input | 16 | Input sample, imaginary part, signed |
| in_valid | input | 1 | Input sample present |
| in_last | input | 1 | Marks the final input block |
| in_ready | output | 1 | Block accepts an input sample |
| out_re | output | 16 | Output sample, real part, signed |
| out_im | output | 16 | Output sample, imaginary part, signed |
| out_valid | output | 1 | Output sample present |
| out_last | output | 1 | Final sample of the final output block |
| out_ready | input | 1 | Downstream takes the output sample |

## Verification
The checks assume that the downstream side eventually raises `out_ready`. Without that, a stalled drain stops the block taking further input. The counters in the checker also assume that the sample counts start fresh at reset. The bench stalls the output at random but always releases it. It holds `in_valid` high with garbage data and `in_last` throughout each update and drain phase, so only the ignored path sees that traffic. It inserts random idle gaps between valid input samples. Two consecutive full-scale blocks force the wrapping sums.

// File: rtl/ola_seq_buffer.sv
module ola_seq_buffer #(
  parameter int K    = 2,
  parameter int NFFT = 8,
  parameter int DW   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  input  logic                 in_valid,
  input  logic                 in_last,
  output logic                 in_ready,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im,
  output logic                 out_valid,
  output logic                 out_last,
  input  logic                 out_ready
);
  localparam int HALF  = NFFT / 2;
  localparam int BLK   = K * NFFT;
  localparam int DEPTH = 2 * BLK;
  localparam int AW    = $clog2(DEPTH);
  localparam int SW    = $clog2(BLK);
  localparam int CW    = AW + 1;

  typedef enum logic [2:0] {S_CLR, S_FILL, S_UPD, S_PRIME, S_DRAIN} state_t;
  state_t state;

  logic [2*DW-1:0] buf_mem [DEPTH];
  logic [2*DW-1:0] stg_mem [BLK];

  logic [CW-1:0]   cnt;
  logic [SW-1:0]   sidx;
  logic [AW-1:0]   oidx;
  logic            blk_last;

  logic            p_vld, p_keep, p_add;
  logic [AW-1:0]   p_addr;

  logic [AW-1:0]   buf_raddr, buf_waddr;
  logic [2*DW-1:0] buf_rdata, buf_wdata, stg_rdata;
  logic            buf_we, stg_we;
  logic [SW-1:0]   stg_raddr;

  logic [DW-1:0]   old_re, old_im, add_re, add_im;

  assign in_ready  = (state == S_FILL);
  assign stg_we    = in_ready && in_valid;
  assign out_valid = (state == S_DRAIN);
  assign out_re    = buf_rdata[2*DW-1:DW];
  assign out_im    = buf_rdata[DW-1:0];
  assign out_last  = out_valid && blk_last && (oidx == AW'(BLK-1));

  assign stg_raddr = SW'(cnt - CW'(BLK));

  always_comb begin
    case (state)
      S_UPD:   buf_raddr = AW'(cnt + CW'(HALF));
      S_DRAIN: buf_raddr = out_ready ? oidx + 1'b1 : oidx;
      default: buf_raddr = '0;
    endcase
  end

  assign old_re = p_keep ? buf_rdata[2*DW-1:DW] : '0;
  assign old_im = p_keep ? buf_rdata[DW-1:0]    : '0;
  assign add_re = p_add  ? stg_rdata[2*DW-1:DW] : '0;
  assign add_im = p_add  ? stg_rdata[DW-1:0]    : '0;

  assign buf_we    = (state == S_CLR) || p_vld;
  assign buf_waddr = (state == S_CLR) ? AW'(cnt) : p_addr;
  assign buf_wdata = (state == S_CLR) ? '0 : {old_re + add_re, old_im + add_im};

  always_ff @(posedge clk) begin
    if (buf_we) buf_mem[buf_waddr] <= buf_wdata;
    buf_rdata <= buf_mem[buf_raddr];
    if (stg_we) stg_mem[sidx] <= {in_re, in_im};
    stg_rdata <= stg_mem[stg_raddr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_CLR;
      cnt      <= '0;
      sidx     <= '0;
      oidx     <= '0;
      blk_last <= 1'b0;
      p_vld    <= 1'b0;
      p_keep   <= 1'b0;
      p_add    <= 1'b0;
      p_addr   <= '0;
    end else begin
      p_vld  <= (state == S_UPD) && (cnt < CW'(DEPTH));
      p_addr <= AW'(cnt);
      p_keep <= cnt < CW'(DEPTH - HALF);
      p_add  <= cnt >= CW'(BLK);
      case (state)
        S_CLR: begin
          if (cnt == CW'(DEPTH-1)) begin
            cnt   <= '0;
            state <= S_FILL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_FILL: begin
          if (in_valid) begin
            blk_last <= blk_last | in_last;
            if (sidx == SW'(BLK-1)) begin
              sidx  <= '0;
              cnt   <= '0;
              state <= S_UPD;
            end else begin
              sidx <= sidx + 1'b1;
            end
          end
        end
        S_UPD: begin
          if (cnt == CW'(DEPTH)) begin
            cnt   <= '0;
            state <= S_PRIME;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PRIME: state <= S_DRAIN;
        S_DRAIN: begin
          if (out_ready) begin
            if (oidx == AW'(BLK-1)) begin
              oidx     <= '0;
              blk_last <= 1'b0;
              state    <= S_FILL;
            end else begin
              oidx <= oidx + 1'b1;
            end
          end
        end
        default: state <= S_CLR;
      endcase
    end
  end
endmodule

// File: rtl/ola_seq_buffer_chk.sv
module ola_seq_buffer_chk #(
  parameter int BLK = 16,
  parameter int DW  = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          out_last,
  input logic [DW-1:0] out_re,
  input logic [DW-1:0] out_im
);
  int acc_cnt;
  int out_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_cnt <= 0;
      out_cnt <= 0;
    end else begin
      if (in_valid && in_ready) acc_cnt <= (acc_cnt == BLK-1) ? 0 : acc_cnt + 1;
      if (out_valid && out_ready) out_cnt <= (out_cnt == BLK-1) ? 0 : out_cnt + 1;
    end
  end

  a_r2_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  a_r2_block_length: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && acc_cnt == BLK-1) |=> !in_ready);

  a_r6_out_length: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_cnt == BLK-1) |=> !out_valid);

  a_r7_last_position: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && out_cnt == BLK-1));

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im) && $stable(out_last)));
endmodule

bind ola_seq_buffer ola_seq_buffer_chk #(.BLK(K*NFFT), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
  .out_re(out_re), .out_im(out_im)
);

// File: tb/ola_seq_buffer_tb_top.sv
module ola_seq_buffer_tb_top;
  localparam int K = 2, NFFT = 8, DW = 16;
  localparam int HALF = NFFT / 2, BLK = K * NFFT, DEPTH = 2 * BLK;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, in_valid, in_last, in_ready, out_valid, out_last, out_ready;
  logic signed [DW-1:0] in_re, in_im, out_re, out_im;

  ola_seq_buffer #(.K(K), .NFFT(NFFT), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_re(in_re), .in_im(in_im),
    .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .out_re(out_re), .out_im(out_im), .out_valid(out_valid),
    .out_last(out_last), .out_ready(out_ready)
  );

  int n_chk = 0, n_fail = 0;
  logic signed [DW-1:0] mre [DEPTH];
  logic signed [DW-1:0] mim [DEPTH];
  logic signed [DW-1:0] cre [BLK];
  logic signed [DW-1:0] cim [BLK];

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic model_step();
    logic signed [DW-1:0] nre [DEPTH];
    logic signed [DW-1:0] nim [DEPTH];
    for (int i = 0; i < DEPTH; i++) begin
      nre[i] = (i + HALF < DEPTH) ? mre[i+HALF] : '0;
      nim[i] = (i + HALF < DEPTH) ? mim[i+HALF] : '0;
    end
    for (int j = 0; j < BLK; j++) begin
      nre[BLK+j] = nre[BLK+j] + cre[j];
      nim[BLK+j] = nim[BLK+j] + cim[j];
    end
    for (int i = 0; i < DEPTH; i++) begin
      mre[i] = nre[i];
      mim[i] = nim[i];
    end
  endtask

  task automatic send_block(input bit lst);
    for (int j = 0; j < BLK; j++) begin
      if ($urandom % 4 == 0) begin
        in_valid = 1'b0;
        @(posedge clk); #1;
      end
      in_valid = 1'b1;
      in_re    = cre[j];
      in_im    = cim[j];
      in_last  = lst && (j == BLK-1);
      forever begin
        @(negedge clk);
        if (in_ready) break;
      end
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic recv_block(input int b, input bit lst);
    int got = 0;
    bit hold = 0;
    logic [2*DW:0] held;
    in_valid = 1'b1;
    in_last  = 1'b1;
    in_re    = 16'($urandom);
    in_im    = 16'($urandom);
    while (got < BLK) begin
      @(posedge clk); #1;
      out_ready = ($urandom % 3 != 0);
      @(negedge clk);
      chk($sformatf("R2 in_ready low while busy b%0d", b), {63'b0, in_ready}, 64'd0);
      if (hold)
        chk($sformatf("R8 stall hold b%0d i%0d", b, got), {31'b0, out_valid, out_last, out_re, out_im},
            {31'b0, 1'b1, held});
      hold = 0;
      if (out_valid && out_ready) begin
        chk($sformatf("R3 R4 R5 R6 R9 %sre b%0d i%0d", (b == 0) ? "R1 " : "", b, got),
            {48'b0, out_re}, {48'b0, mre[got]});
        chk($sformatf("R3 R4 R5 R6 R9 %sim b%0d i%0d", (b == 0) ? "R1 " : "", b, got),
            {48'b0, out_im}, {48'b0, mim[got]});
        chk($sformatf("R7 last b%0d i%0d", b, got), {63'b0, out_last},
            {63'b0, (lst && got == BLK-1)});
        got++;
      end else if (out_valid) begin
        hold = 1;
        held = {out_last, out_re, out_im};
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    void'($urandom(32'd20240));
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; out_ready = 1'b0;
    in_re = '0; in_im = '0;
    for (int i = 0; i < DEPTH; i++) begin mre[i] = '0; mim[i] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 in_ready low during clear", {63'b0, in_ready}, 64'd0);
    chk("R1 out_valid low during clear", {63'b0, out_valid}, 64'd0);
    for (int b = 0; b < 6; b++) begin
      for (int j = 0; j < BLK; j++) begin
        if (b == 2 || b == 3) begin
          cre[j] = 16'sh7FFF;
          cim[j] = 16'sh8000;
        end else begin
          cre[j] = 16'($urandom);
          cim[j] = 16'($urandom);
        end
      end
      send_block(b == 4);
      model_step();
      recv_block(b, b == 4);
    end
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: R2 R6 progress stalled, got hang exp completion");
    summary();
    $finish;
  end
endmodule